// File: doc/BRIEF.md
# UART Automatic RTS/CTS Flow Controller

This block adds automatic hardware flow control to one UART channel with a 16-byte receive FIFO. On the receive side it watches the FIFO fill level against a programmed trigger level. It raises a trigger interrupt request when that level is reached. It releases the active-low ready-to-send output with hysteresis: RTS# goes high at the trigger level one step above the programmed one, and goes low again only when the fill falls below the level one step beneath it. Automatic control only acts when software has already asserted RTS through its control bit. When automatic control is off, the output just mirrors that bit, inverted.

On the transmit side, the active-low clear-to-send input passes through a two-flop synchronizer. Its synchronized value is sampled only at character boundaries, which the transmitter signals. The result is a transmit-permit level that the transmitter checks before it starts the next character. A character already being shifted out therefore always finishes.

Receive FSM states: `RTS_OFF` (software bit clear, RTS# high), `RTS_ON` (RTS# low), `RTS_HOLD` (RTS# released by automatic control). Receive transitions:
- any state goes to `RTS_OFF` when the software bit is clear;
- `RTS_OFF` goes to `RTS_ON`, or straight to `RTS_HOLD` if automatic control is on and the fill is already at the upper level;
- `RTS_ON` goes to `RTS_HOLD` when the fill reaches the upper level;
- `RTS_HOLD` goes to `RTS_ON` when the fill drops below the lower level, or when automatic control is turned off.

Transmit FSM states: `TX_GO` (permit) and `TX_WAIT` (blocked). Transmit transitions:
- `TX_GO` goes to `TX_WAIT` at a boundary when synchronized CTS# is high and automatic CTS is on;
- `TX_WAIT` goes to `TX_GO` at a boundary when CTS# is low, or at once when automatic CTS is turned off.

Top module: `uart_hwflow_ctrl`

## Requirements
- R1: After reset, `rts_n` is 1, `rx_trig_irq` is 0 and `tx_permit` is 1.
- R2: With `auto_rts_en` = 0, `rts_n` equals the inverse of `mcr_rts` one clock later, whatever the fill level.
- R3: With `mcr_rts` = 0, `rts_n` is 1 one clock later, whatever the fill level and enables.
- R4: `rx_trig_sel` codes 0,1,2,3 select trigger levels 1,4,8,14 bytes. With `auto_rts_en` = 1, `rx_trig_irq` is 1 one clock after `rx_fill` is at or above the selected level, and 0 one clock after it is below. With `auto_rts_en` = 0, `rx_trig_irq` is 0.
- R5: With both `auto_rts_en` and `mcr_rts` at 1, `rts_n` goes to 1 one clock after `rx_fill` reaches the upper level. The upper level is 4, 8, 14 or 16 for codes 0 to 3.
- R6: After release, `rts_n` returns to 0 one clock after `rx_fill` drops below the lower level. The lower level is 1, 4 or 8 for codes 1 to 3. For code 0, RTS# returns when the FIFO is empty.
- R7: Between the two levels, `rts_n` keeps its previous value (hysteresis).
- R8: With `auto_cts_en` = 0, `tx_permit` is 1 one clock later, whatever `cts_n` is.
- R9: With `auto_cts_en` = 1 and `tx_char_boundary` = 1, `tx_permit` becomes the inverse of `cts_n`. It changes on the third clock edge after `cts_n` changes.
- R10: With `auto_cts_en` = 1 and `tx_char_boundary` = 0, `tx_permit` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_fill | input | 5 | Receive FIFO fill level, 0 to 16 |
| rx_trig_sel | input | 2 | Receive trigger-level select code |
| mcr_rts | input | 1 | Software RTS control bit, 1 = assert |
| auto_rts_en | input | 1 | Automatic RTS enable |
| auto_cts_en | input | 1 | Automatic CTS enable |
| cts_n | input | 1 | Active-low clear-to-send input (asynchronous) |
| tx_char_boundary | input | 1 | Transmitter is between characters |
| rts_n | output | 1 | Active-low ready-to-send output |
| rx_trig_irq | output | 1 | Receive trigger interrupt request |
| tx_permit | output | 1 | Transmitter may start the next character |

## Verification
The in-RTL assertions check these properties on every cycle:
- RTS# follows the software bit when automatic control is off, and is forced high when that bit is clear;
- RTS# is released whenever the fill is at the upper level;
- the released state is not left while the fill stays at or above the lower level;
- the transmit permit never moves outside a character boundary while automatic CTS is on.

Only the bench's sweeps can show the following:
- the actual threshold numbers for each select code;
- the full up-and-down hysteresis path;
- the interrupt level against the fill;
- the three-edge latency from CTS# to the permit.

// File: rtl/uart_hwflow_pkg.sv
package uart_hwflow_pkg;
    typedef enum logic [1:0] {
        RTS_OFF  = 2'd0,
        RTS_ON   = 2'd1,
        RTS_HOLD = 2'd2
    } rts_state_e;

    typedef enum logic {
        TX_GO   = 1'b0,
        TX_WAIT = 1'b1
    } tx_state_e;
endpackage

// File: rtl/uart_rts_ctrl.sv
module uart_rts_ctrl
    import uart_hwflow_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int TRIG_L0 = 1,
    parameter int TRIG_L1 = 4,
    parameter int TRIG_L2 = 8,
    parameter int TRIG_L3 = 14,
    parameter int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fill,
    input  logic [1:0]       sel,
    input  logic             mcr_rts,
    input  logic             auto_en,
    output logic             rts_n,
    output logic             trig_irq
);
    rts_state_e state, state_nx;
    logic [LVL_W-1:0] lvl_trig, lvl_up, lvl_lo;

    // Threshold selection; the lower level of code 0 means "empty".
    always_comb begin
        unique case (sel)
            2'd0: begin lvl_trig = LVL_W'(TRIG_L0); lvl_up = LVL_W'(TRIG_L1); lvl_lo = LVL_W'(1);       end
            2'd1: begin lvl_trig = LVL_W'(TRIG_L1); lvl_up = LVL_W'(TRIG_L2); lvl_lo = LVL_W'(TRIG_L0); end
            2'd2: begin lvl_trig = LVL_W'(TRIG_L2); lvl_up = LVL_W'(TRIG_L3); lvl_lo = LVL_W'(TRIG_L1); end
            default: begin lvl_trig = LVL_W'(TRIG_L3); lvl_up = LVL_W'(DEPTH); lvl_lo = LVL_W'(TRIG_L2); end
        endcase
    end

    always_comb begin
        state_nx = state;
        if (!mcr_rts) begin
            state_nx = RTS_OFF;
        end else begin
            unique case (state)
                RTS_OFF:  state_nx = (auto_en && fill >= lvl_up) ? RTS_HOLD : RTS_ON;
                RTS_ON:   if (auto_en && fill >= lvl_up) state_nx = RTS_HOLD;
                RTS_HOLD: if (!auto_en || fill < lvl_lo) state_nx = RTS_ON;
                default:  state_nx = RTS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RTS_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_irq <= 1'b0;
        else        trig_irq <= auto_en && (fill >= lvl_trig);
    end

    always_comb rts_n = (state != RTS_ON);

    // R3
    mcr_clear_forces_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mcr_rts |=> rts_n);
    // R2
    plain_output_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && mcr_rts) |=> !rts_n);
    // R5
    upper_level_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && mcr_rts && fill >= lvl_up) |=> rts_n);
    // R7
    hold_hysteresis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RTS_HOLD && auto_en && mcr_rts && fill >= lvl_lo) |=> state == RTS_HOLD);
    // R4
    irq_needs_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> !trig_irq);
endmodule

// File: rtl/uart_cts_gate.sv
module uart_cts_gate
    import uart_hwflow_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    input  logic auto_en,
    input  logic char_boundary,
    output logic permit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic cts_n_s;
    tx_state_e state, state_nx;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= cts_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], cts_n};
            end
        end
    endgenerate

    always_comb cts_n_s = sync_q[SYNC_STAGES-1];

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_GO:   if (auto_en && char_boundary && cts_n_s) state_nx = TX_WAIT;
            TX_WAIT: if (!auto_en || (char_boundary && !cts_n_s)) state_nx = TX_GO;
            default: state_nx = TX_GO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_GO;
        else        state <= state_nx;
    end

    always_comb permit = (state == TX_GO);

    // R10
    mid_char_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !char_boundary) |=> $stable(permit));
    // R8
    cts_off_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> permit);
endmodule

// File: rtl/uart_hwflow_ctrl.sv
module uart_hwflow_ctrl #(
    parameter int DEPTH   = 16,
    parameter int TRIG_L0 = 1,
    parameter int TRIG_L1 = 4,
    parameter int TRIG_L2 = 8,
    parameter int TRIG_L3 = 14,
    parameter int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_fill,
    input  logic [1:0]       rx_trig_sel,
    input  logic             mcr_rts,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             cts_n,
    input  logic             tx_char_boundary,
    output logic             rts_n,
    output logic             rx_trig_irq,
    output logic             tx_permit
);
    uart_rts_ctrl #(
        .DEPTH(DEPTH), .TRIG_L0(TRIG_L0), .TRIG_L1(TRIG_L1),
        .TRIG_L2(TRIG_L2), .TRIG_L3(TRIG_L3), .LVL_W(LVL_W)
    ) u_rts (
        .clk(clk), .rst_n(rst_n), .fill(rx_fill), .sel(rx_trig_sel),
        .mcr_rts(mcr_rts), .auto_en(auto_rts_en),
        .rts_n(rts_n), .trig_irq(rx_trig_irq)
    );

    uart_cts_gate #(.SYNC_STAGES(2)) u_cts (
        .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .auto_en(auto_cts_en),
        .char_boundary(tx_char_boundary), .permit(tx_permit)
    );

    // R1
    reset_release_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (rts_n && !rx_trig_irq && tx_permit));
endmodule

// File: tb/uart_hwflow_ctrl_test.sv
module uart_hwflow_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] rx_fill = '0;
    logic [1:0] rx_trig_sel = '0;
    logic mcr_rts = 1'b0, auto_rts_en = 1'b0, auto_cts_en = 1'b0;
    logic cts_n = 1'b1, tx_char_boundary = 1'b0;
    logic rts_n, rx_trig_irq, tx_permit;
    int checks = 0, errors = 0;
    bit hold_m = 1'b0;

    always #4 clk = ~clk;

    uart_hwflow_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .rx_trig_sel(rx_trig_sel),
        .mcr_rts(mcr_rts), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
        .cts_n(cts_n), .tx_char_boundary(tx_char_boundary),
        .rts_n(rts_n), .rx_trig_irq(rx_trig_irq), .tx_permit(tx_permit)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int trig_of(input int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
    endfunction
    function automatic int up_of(input int s);
        return (s == 3) ? 16 : trig_of(s + 1);
    endfunction
    function automatic int lo_of(input int s);
        return (s == 0) ? 1 : trig_of(s - 1);
    endfunction

    // Apply one fill value and compare with the hysteresis model
    task automatic rts_step(input int s, input int f);
        rx_fill = 5'(f);
        if (!hold_m && f >= up_of(s)) hold_m = 1'b1;
        else if (hold_m && f < lo_of(s)) hold_m = 1'b0;
        tick();
        chk("R5/R6/R7 rts_n", rts_n, hold_m);
        chk("R4 rx_trig_irq", rx_trig_irq, f >= trig_of(s));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rts_n", rts_n, 1'b1);
        chk("R1 irq", rx_trig_irq, 1'b0);
        chk("R1 permit", tx_permit, 1'b1);
        rst_n = 1'b1;
        tick();

        // R2: automatic RTS off, output mirrors the software bit
        auto_rts_en = 1'b0;
        for (int f = 0; f <= 16; f += 4) begin
            for (int m = 0; m < 2; m++) begin
                rx_fill = 5'(f); mcr_rts = m[0]; rx_trig_sel = 2'(f % 4);
                tick();
                chk("R2 rts_n", rts_n, ~m[0]);
                chk("R4 irq off", rx_trig_irq, 1'b0);
            end
        end

        // R3: software bit clear keeps RTS# high
        auto_rts_en = 1'b1; mcr_rts = 1'b0;
        for (int f = 0; f <= 16; f++) begin
            rx_fill = 5'(f);
            tick();
            chk("R3 rts_n", rts_n, 1'b1);
        end

        // R4..R7: full up/down sweeps per select code
        for (int s = 0; s < 4; s++) begin
            mcr_rts = 1'b0; rx_fill = '0; rx_trig_sel = 2'(s);
            tick();
            mcr_rts = 1'b1; hold_m = 1'b0;
            for (int f = 0; f <= 16; f++) rts_step(s, f);
            for (int f = 16; f >= 0; f--) rts_step(s, f);
            for (int f = 0; f <= up_of(s); f++) rts_step(s, f);
            rts_step(s, lo_of(s));
            rts_step(s, up_of(s));
        end

        // R2: turning automatic RTS off while released re-asserts
        rx_trig_sel = 2'd1; rx_fill = 5'd10; mcr_rts = 1'b1; auto_rts_en = 1'b1;
        tick(); tick();
        chk("R5 rts released", rts_n, 1'b1);
        auto_rts_en = 1'b0;
        tick();
        chk("R2 auto off reasserts", rts_n, 1'b0);

        // R8: automatic CTS off
        auto_cts_en = 1'b0; cts_n = 1'b1; tx_char_boundary = 1'b1;
        repeat (4) tick();
        chk("R8 permit", tx_permit, 1'b1);

        // R9: latency, R10: no change mid-character
        auto_cts_en = 1'b1; tx_char_boundary = 1'b0;
        repeat (5) begin
            tick();
            chk("R10 permit mid char", tx_permit, 1'b1);
        end
        tx_char_boundary = 1'b1;
        tick();
        chk("R9 stop", tx_permit, 1'b0);
        cts_n = 1'b0;
        tick(); tick();
        chk("R9 not yet", tx_permit, 1'b0);
        tick();
        chk("R9 resume", tx_permit, 1'b1);
        cts_n = 1'b1; tx_char_boundary = 1'b0;
        repeat (6) begin
            tick();
            chk("R10 held", tx_permit, 1'b1);
        end
        tx_char_boundary = 1'b1;
        tick();
        chk("R9 stop at boundary", tx_permit, 1'b0);
        auto_cts_en = 1'b0; tx_char_boundary = 1'b0;
        tick();
        chk("R8 release on disable", tx_permit, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule